// File: doc/BRIEF.md
# Clock source switching controller

This block decides which of two oscillators drives the CPU and when the CPU receives clock at all. Each oscillator is represented by a tick strobe in the reference clock domain, where one strobe marks one edge of that oscillator. The block turns those strobes into a single CPU clock enable. After reset the internal oscillator is the CPU clock, but the enable stays low for a fixed number of internal ticks. Software may later move the CPU onto the high-speed oscillator. That move is accepted only once a stabilization counter shows that the selected settling time has passed. When the high-speed source is an RC network, the wait does not apply.

The block also owns the run/stop controls of both oscillators. A stop request is honoured only when the oscillator is not the one feeding the CPU. A STOP-mode entry gates the CPU and halts the high-speed oscillator. On wake-up with the high-speed clock selected, the CPU waits for a fresh stabilization count before it resumes. The state machine has these states: `ST_BOOT_HOLD`, `ST_RUN_INT`, `ST_LEAVE_INT`, `ST_SYNC_HS`, `ST_RUN_HS`, `ST_LEAVE_HS`, `ST_SYNC_INT`, `ST_STOPPED` and `ST_WAKE_WAIT`.

It has these transitions:
- boot-done: `ST_BOOT_HOLD` to `ST_RUN_INT`
- switch-up: `ST_RUN_INT` to `ST_LEAVE_INT` to `ST_SYNC_HS` to `ST_RUN_HS`
- switch-down: `ST_RUN_HS` to `ST_LEAVE_HS` to `ST_SYNC_INT` to `ST_RUN_INT`
- sleep: either run state to `ST_STOPPED`
- wake-int: `ST_STOPPED` to `ST_RUN_INT`
- wake-hs: `ST_STOPPED` to `ST_WAKE_WAIT` to `ST_RUN_HS`

Top module: `clksw_ctrl`

## Requirements
- R1: While `rst_n` is low, `cpu_clk_en`, `clk_status`, `hs_osc_on`, `int_osc_on` and `stab_flags` are all 0. Both oscillator enables rise on the first clock edge after reset release.
- R2: After reset release, `cpu_clk_en` stays 0 until 17 internal ticks have been counted, where a tick counts only while `int_osc_on` is 1. From the next cycle on, `cpu_clk_en` follows `int_tick`.
- R3: `stab_flags` holds sticky bits that count high-speed ticks seen while `hs_osc_on` is 1. Bit 0 sets at 2^11 ticks, bit 1 at 2^13, bit 2 at 2^14, bit 3 at 2^15 and bit 4 at 2^16. Each bit sets on the edge that counts its threshold tick.
- R4: `stab_sel` code n, for n from 0 to 4, selects flag bit n as the switch condition. Codes 5 to 7 select bit 4.
- R5: A switch request (`sel_wr` with `sel_val`=1) is ignored while the selected flag is 0 and `rc_mode` is 0. In that case `clk_status` stays 0 and the CPU keeps the internal clock.
- R6: An accepted switch to the high-speed clock drops `cpu_clk_en` on the next cycle. The block then waits one internal tick and two high-speed ticks. With every tick present, `clk_status` becomes 1 four cycles after the request, and from then on `cpu_clk_en` follows `hs_tick` only.
- R7: With `rc_mode`=1, a switch to the high-speed clock is accepted without regard to the flags.
- R8: `hs_stop` turns off the high-speed oscillator only while the internal clock drives the CPU. Otherwise it has no effect.
- R9: `int_stop` turns off the internal oscillator only while the high-speed clock drives the CPU and `int_stop_ok` is 1. Otherwise it has no effect.
- R10: `hs_start` with the high-speed oscillator off turns it on, clears every flag and restarts the count from zero. A STOP entry also clears the flags.
- R11: `stop_enter` in a run state gates `cpu_clk_en` and turns off the high-speed oscillator. On `wake` with `clk_status`=0, the CPU resumes on the internal clock the next cycle. On `wake` with `clk_status`=1, the high-speed oscillator restarts and the CPU stays gated until the selected flag is set.
- R12: A switch back to the internal clock (`sel_wr` with `sel_val`=0) is ignored while `int_osc_on` is 0. When accepted, it runs the mirror sequence: one high-speed tick, then two internal ticks, then `clk_status` becomes 0 four cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| int_tick | input | 1 | Internal oscillator edge strobe |
| hs_tick | input | 1 | High-speed oscillator edge strobe |
| sel_wr | input | 1 | Clock-select write strobe |
| sel_val | input | 1 | Requested source: 1 high-speed, 0 internal |
| hs_start | input | 1 | Start request for high-speed oscillator |
| hs_stop | input | 1 | Stop request for high-speed oscillator |
| int_start | input | 1 | Start request for internal oscillator |
| int_stop | input | 1 | Stop request for internal oscillator |
| stab_sel | input | 3 | Stabilization threshold code |
| rc_mode | input | 1 | Strap: high-speed source is RC, no wait |
| int_stop_ok | input | 1 | Strap: software may stop internal oscillator |
| stop_enter | input | 1 | STOP-mode entry strobe |
| wake | input | 1 | STOP-mode wake event |
| cpu_clk_en | output | 1 | Gated CPU clock enable |
| clk_status | output | 1 | 1 when the high-speed clock drives the CPU |
| hs_osc_on | output | 1 | High-speed oscillator run enable |
| int_osc_on | output | 1 | Internal oscillator run enable |
| stab_flags | output | 5 | Sticky stabilization threshold flags |

## Verification
Outputs that come straight from the tick strobes, such as `cpu_clk_en` in a run state, are due in the same cycle as the stimulus. Oscillator enables, flags and state-driven results are due one edge after a request. Changeovers complete four edges after the request when every tick is present. Flags land 2049 edges after the counter restarts, and the gated wake lasts 2050 edges. Inputs are driven 2 ns after each rising edge. Every expected item carries the absolute cycle it is due in, and the scoreboard compares it at the falling edge of exactly that cycle. Any item left behind its due cycle counts as a failure.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic [3:0] {
        ST_BOOT_HOLD,
        ST_RUN_INT,
        ST_LEAVE_INT,
        ST_SYNC_HS,
        ST_RUN_HS,
        ST_LEAVE_HS,
        ST_SYNC_INT,
        ST_STOPPED,
        ST_WAKE_WAIT
    } clksw_state_e;

    // Threshold exponent for flag index idx: the first is separate, the rest step by one.
    function automatic int thr_log2(input int idx, input int first_log2, input int next_log2);
        return (idx == 0) ? first_log2 : next_log2 + idx - 1;
    endfunction

endpackage

// File: rtl/clksw_tick_counter.sv
module clksw_tick_counter #(
    parameter int W       = 5,
    parameter int RST_VAL = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - W'(1);
        end
    end

    // The controller leaves a counting state on the count of one, so it never decrements zero.
    assert_hold_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt != '0));

endmodule

// File: rtl/clksw_stab_counter.sv
module clksw_stab_counter
    import clksw_pkg::*;
#(
    parameter int FIRST_LOG2 = 11,
    parameter int NEXT_LOG2  = 13,
    parameter int NUM_THR    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               tick,
    output logic [NUM_THR-1:0] flags
);

    localparam int TOP_LOG2 = thr_log2(NUM_THR - 1, FIRST_LOG2, NEXT_LOG2);
    localparam int CNT_W    = TOP_LOG2 + 1;

    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   count_nxt;
    logic               saturated;
    logic [NUM_THR-1:0] hit;

    assign saturated = count[CNT_W-1];
    assign count_nxt = count + CNT_W'(1);

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        localparam int               LOG2 = thr_log2(g, FIRST_LOG2, NEXT_LOG2);
        localparam logic [CNT_W-1:0] THR  = CNT_W'(1) << LOG2;
        assign hit[g] = tick && !saturated && (count_nxt == THR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            flags <= '0;
        end else if (clr) begin
            count <= '0;
            flags <= '0;
        end else begin
            if (tick && !saturated) begin
                count <= count_nxt;
            end
            flags <= flags | hit;
        end
    end

    // Flags are sticky between clears.
    assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    // A longer threshold can only be passed after every shorter one.
    for (genvar g = 1; g < NUM_THR; g++) begin : g_order
        assert_flags_ordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
            flags[g] |-> flags[g-1]);
    end

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int HOLD_TICKS = 17,
    parameter int SYNC_EDGES = 2,
    parameter int FIRST_LOG2 = 11,
    parameter int NEXT_LOG2  = 13,
    parameter int NUM_THR    = 5,
    parameter int SEL_W      = $clog2(NUM_THR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               int_tick,
    input  logic               hs_tick,
    input  logic               sel_wr,
    input  logic               sel_val,
    input  logic               hs_start,
    input  logic               hs_stop,
    input  logic               int_start,
    input  logic               int_stop,
    input  logic [SEL_W-1:0]   stab_sel,
    input  logic               rc_mode,
    input  logic               int_stop_ok,
    input  logic               stop_enter,
    input  logic               wake,
    output logic               cpu_clk_en,
    output logic               clk_status,
    output logic               hs_osc_on,
    output logic               int_osc_on,
    output logic [NUM_THR-1:0] stab_flags
);

    localparam int CNT_MAX = (HOLD_TICKS > SYNC_EDGES) ? HOLD_TICKS : SYNC_EDGES;
    localparam int HOLD_W  = $clog2(CNT_MAX + 1);

    clksw_state_e state, state_nxt;

    logic              powered;
    logic              int_q, hs_q;
    logic              int_eff, hs_eff;
    logic [SEL_W-1:0]  stab_idx;
    logic              stab_done;
    logic              go_hs, go_int;
    logic              hs_stop_acc, int_stop_acc;
    logic              hs_start_acc, int_start_acc;
    logic              stop_acc, wake_acc;
    logic              stab_clr;
    logic              cnt_load, cnt_dec;
    logic [HOLD_W-1:0] cnt;
    logic              cnt_last;

    // ---------------- oscillator gating ----------------
    assign int_osc_on = int_q & powered;
    assign hs_osc_on  = hs_q & powered;
    assign int_eff    = int_tick & int_osc_on;
    assign hs_eff     = hs_tick & hs_osc_on;

    // ---------------- stabilization ----------------
    assign stab_idx  = (int'(stab_sel) >= NUM_THR) ? SEL_W'(NUM_THR - 1) : stab_sel;
    assign stab_done = rc_mode | stab_flags[stab_idx];
    assign stab_clr  = stop_acc | hs_start_acc | wake_acc;

    clksw_stab_counter #(
        .FIRST_LOG2 (FIRST_LOG2),
        .NEXT_LOG2  (NEXT_LOG2),
        .NUM_THR    (NUM_THR)
    ) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stab_clr),
        .tick  (hs_eff),
        .flags (stab_flags)
    );

    // ---------------- request qualification ----------------
    always_comb begin
        go_hs         = (state == ST_RUN_INT) && sel_wr && sel_val && hs_osc_on && stab_done;
        go_int        = (state == ST_RUN_HS) && sel_wr && !sel_val && int_osc_on;
        hs_stop_acc   = hs_stop && ((state == ST_BOOT_HOLD) || (state == ST_RUN_INT));
        int_stop_acc  = int_stop && int_stop_ok && (state == ST_RUN_HS);
        hs_start_acc  = hs_start && !hs_q && (state != ST_STOPPED) && (state != ST_WAKE_WAIT);
        int_start_acc = int_start && !int_q;
        stop_acc      = stop_enter && ((state == ST_RUN_INT) || (state == ST_RUN_HS));
        wake_acc      = wake && (state == ST_STOPPED);
    end

    // ---------------- shared boot-hold / sync counter ----------------
    assign cnt_last = (cnt == HOLD_W'(1));

    clksw_tick_counter #(
        .W       (HOLD_W),
        .RST_VAL (HOLD_TICKS)
    ) u_ticks (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (HOLD_W'(SYNC_EDGES)),
        .dec      (cnt_dec),
        .cnt      (cnt)
    );

    always_comb begin
        cnt_load = ((state == ST_LEAVE_INT) && int_eff) || ((state == ST_LEAVE_HS) && hs_eff);
        cnt_dec  = ((state == ST_BOOT_HOLD) && int_eff && !cnt_last)
                || ((state == ST_SYNC_HS) && hs_eff && !cnt_last)
                || ((state == ST_SYNC_INT) && int_eff && !cnt_last);
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_BOOT_HOLD: if (int_eff && cnt_last) state_nxt = ST_RUN_INT;
            ST_RUN_INT: begin
                if (stop_acc)   state_nxt = ST_STOPPED;
                else if (go_hs) state_nxt = ST_LEAVE_INT;
            end
            ST_LEAVE_INT: if (int_eff) state_nxt = ST_SYNC_HS;
            ST_SYNC_HS:   if (hs_eff && cnt_last) state_nxt = ST_RUN_HS;
            ST_RUN_HS: begin
                if (stop_acc)    state_nxt = ST_STOPPED;
                else if (go_int) state_nxt = ST_LEAVE_HS;
            end
            ST_LEAVE_HS:  if (hs_eff) state_nxt = ST_SYNC_INT;
            ST_SYNC_INT:  if (int_eff && cnt_last) state_nxt = ST_RUN_INT;
            ST_STOPPED:   if (wake_acc) state_nxt = clk_status ? ST_WAKE_WAIT : ST_RUN_INT;
            ST_WAKE_WAIT: if (stab_done) state_nxt = ST_RUN_HS;
            default:      state_nxt = ST_BOOT_HOLD;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_BOOT_HOLD;
            clk_status <= 1'b0;
        end else begin
            state <= state_nxt;
            if ((state == ST_SYNC_HS) && (state_nxt == ST_RUN_HS)) begin
                clk_status <= 1'b1;
            end else if ((state == ST_SYNC_INT) && (state_nxt == ST_RUN_INT)) begin
                clk_status <= 1'b0;
            end
        end
    end

    // ---------------- oscillator enables ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            powered <= 1'b0;
            int_q   <= 1'b1;
            hs_q    <= 1'b1;
        end else begin
            powered <= 1'b1;
            if (int_stop_acc) begin
                int_q <= 1'b0;
            end else if (int_start_acc) begin
                int_q <= 1'b1;
            end
            if (stop_acc || hs_stop_acc) begin
                hs_q <= 1'b0;
            end else if ((wake_acc && clk_status) || hs_start_acc) begin
                hs_q <= 1'b1;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        cpu_clk_en = 1'b0;
        unique case (state)
            ST_RUN_INT: cpu_clk_en = int_eff;
            ST_RUN_HS:  cpu_clk_en = hs_eff;
            default:    cpu_clk_en = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    assert_cpu_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (clk_status ? (hs_tick && hs_osc_on) : (int_tick && int_osc_on)));

    assert_switch_needs_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_status) |-> (rc_mode || stab_flags[stab_idx]));

    assert_hs_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_status && hs_osc_on && !stop_enter) |=> hs_osc_on);

    assert_int_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_status && int_osc_on) |=> int_osc_on);

    assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOPPED) |-> (!cpu_clk_en && !hs_osc_on));

endmodule

// File: tb/clksw_ctrl_tb.sv
module clksw_ctrl_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, int_tick, hs_tick, sel_wr, sel_val, hs_start, hs_stop;
    logic       int_start, int_stop, rc_mode, int_stop_ok, stop_enter, wake;
    logic [2:0] stab_sel;
    logic       cpu_clk_en, clk_status, hs_osc_on, int_osc_on;
    logic [4:0] stab_flags;

    clksw_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .hs_tick(hs_tick),
        .sel_wr(sel_wr), .sel_val(sel_val), .hs_start(hs_start), .hs_stop(hs_stop),
        .int_start(int_start), .int_stop(int_stop), .stab_sel(stab_sel),
        .rc_mode(rc_mode), .int_stop_ok(int_stop_ok), .stop_enter(stop_enter),
        .wake(wake), .cpu_clk_en(cpu_clk_en), .clk_status(clk_status),
        .hs_osc_on(hs_osc_on), .int_osc_on(int_osc_on), .stab_flags(stab_flags)
    );

    localparam logic [8:0] M_EN  = 9'h100;
    localparam logic [8:0] M_ST  = 9'h080;
    localparam logic [8:0] M_HS  = 9'h040;
    localparam logic [8:0] M_INT = 9'h020;
    localparam logic [8:0] M_FL  = 9'h01F;
    localparam logic [8:0] M_ALL = 9'h1FF;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 0;

    int         q_due[$];
    logic [8:0] q_mask[$];
    logic [8:0] q_val[$];
    string      q_tag[$];

    wire [8:0] obs = {cpu_clk_en, clk_status, hs_osc_on, int_osc_on, stab_flags};

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: push an expected item due d edges from now.
    task automatic expect_at(input int d, input logic [8:0] m, input logic [8:0] v, input string tag);
        q_due.push_back(cyc + d);
        q_mask.push_back(m);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Monitor side: compare every item due in this cycle.
    always @(negedge clk) begin
        for (int i = q_due.size() - 1; i >= 0; i--) begin
            if (q_due[i] <= cyc) begin
                n_chk++;
                if (q_due[i] < cyc || ((obs & q_mask[i]) != (q_val[i] & q_mask[i]))) begin
                    n_err++;
                    $display("FAIL %s cycle=%0d actual=%b expected=%b mask=%b",
                             q_tag[i], cyc, obs & q_mask[i], q_val[i] & q_mask[i], q_mask[i]);
                end
                q_due.delete(i);
                q_mask.delete(i);
                q_val.delete(i);
                q_tag.delete(i);
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; int_tick = 1; hs_tick = 1; sel_wr = 0; sel_val = 0;
        hs_start = 0; hs_stop = 0; int_start = 0; int_stop = 0; stab_sel = 0;
        rc_mode = 0; int_stop_ok = 1; stop_enter = 0; wake = 0;
        step(3);
        expect_at(0, M_ALL, 9'h000, "R1");
        step(1);

        // Boot: hold, then the first flags.
        rst_n = 1;
        expect_at(1, M_HS | M_INT, M_HS | M_INT, "R1");
        expect_at(17, M_EN, 9'h000, "R2");
        expect_at(18, M_EN, M_EN, "R2");
        expect_at(2048, M_FL, 9'h000, "R3");
        expect_at(2049, M_FL, 9'h001, "R3");
        expect_at(8192, M_FL, 9'h001, "R3");
        expect_at(8193, M_FL, 9'h003, "R3");
        step(30);

        // Internal stop while internal is CPU clock: ignored.
        int_stop = 1;
        expect_at(1, M_INT, M_INT, "R9");
        step(1); int_stop = 0;

        // Early switch request: rejected.
        sel_val = 1; sel_wr = 1;
        expect_at(5, M_ST | M_EN, M_EN, "R5");
        step(1); sel_wr = 0;
        step(2960);

        // Flag 0 set, flag 1 not: code 1 and code 5 both reject.
        stab_sel = 1; sel_wr = 1;
        expect_at(5, M_ST | M_EN, M_EN, "R4");
        step(1); sel_wr = 0; step(2);
        stab_sel = 5; sel_wr = 1;
        expect_at(5, M_ST | M_EN, M_EN, "R4");
        step(1); sel_wr = 0;
        step(5300);

        // Accepted changeover to the high-speed clock.
        stab_sel = 1; sel_wr = 1;
        expect_at(0, M_EN | M_ST, M_EN, "R6");
        expect_at(1, M_EN | M_ST, 9'h000, "R6");
        expect_at(3, M_EN | M_ST, 9'h000, "R6");
        expect_at(4, M_EN | M_ST, M_EN | M_ST, "R4");
        step(1); sel_wr = 0; step(5);
        int_tick = 0;
        expect_at(0, M_EN | M_ST, M_EN | M_ST, "R6");
        step(1);
        hs_tick = 0;
        expect_at(0, M_EN, 9'h000, "R6");
        step(1);
        hs_tick = 1; int_tick = 1; step(2);

        // High-speed stop while it drives the CPU: ignored.
        hs_stop = 1;
        expect_at(1, M_HS, M_HS, "R8");
        expect_at(2, M_HS, M_HS, "R8");
        step(1); hs_stop = 0; step(2);

        // Internal stop: strap off ignored, strap on honoured.
        int_stop_ok = 0; int_stop = 1;
        expect_at(1, M_INT, M_INT, "R9");
        step(1); int_stop = 0; step(2);
        int_stop_ok = 1; int_stop = 1;
        expect_at(1, M_INT, 9'h000, "R9");
        step(1); int_stop = 0; step(2);

        // Switch back with internal off: rejected; then restart and switch.
        sel_val = 0; sel_wr = 1;
        expect_at(5, M_ST | M_EN, M_ST | M_EN, "R12");
        step(1); sel_wr = 0; step(6);
        int_start = 1;
        expect_at(1, M_INT, M_INT, "R12");
        step(1); int_start = 0; step(2);
        sel_val = 0; sel_wr = 1;
        expect_at(1, M_EN | M_ST, M_ST, "R12");
        expect_at(3, M_EN | M_ST, M_ST, "R12");
        expect_at(4, M_EN | M_ST, M_EN, "R12");
        step(1); sel_wr = 0; step(5);

        // High-speed stop on internal clock: honoured, flag 0 kept.
        hs_stop = 1;
        expect_at(1, M_HS | 9'h001, 9'h001, "R8");
        step(1); hs_stop = 0; step(2);

        // Restart clears flags and recounts; RC mode switches at once.
        stab_sel = 0; hs_start = 1;
        expect_at(1, M_HS | M_FL, M_HS, "R10");
        expect_at(2048, M_FL, 9'h000, "R10");
        expect_at(2049, M_FL, 9'h001, "R10");
        step(1); hs_start = 0; step(2);
        rc_mode = 1; sel_val = 1; sel_wr = 1;
        expect_at(4, M_ST | M_EN, M_ST | M_EN, "R7");
        step(1); sel_wr = 0; step(5);
        rc_mode = 0;
        step(2060);

        // STOP with high-speed clock, wake waits for the count.
        stop_enter = 1;
        expect_at(1, M_EN | M_HS | M_FL | M_ST, M_ST, "R11");
        step(1); stop_enter = 0; step(10);
        expect_at(0, M_EN, 9'h000, "R11");
        wake = 1;
        expect_at(1, M_HS | M_EN, M_HS, "R11");
        expect_at(2049, M_EN | M_FL, 9'h001, "R11");
        expect_at(2050, M_EN | M_ST, M_EN | M_ST, "R11");
        step(1); wake = 0;
        step(2055);

        // STOP with internal clock, wake resumes at once.
        sel_val = 0; sel_wr = 1;
        step(1); sel_wr = 0; step(6);
        stop_enter = 1;
        expect_at(1, M_EN | M_HS, 9'h000, "R11");
        step(1); stop_enter = 0; step(3);
        wake = 1;
        expect_at(1, M_EN | M_HS | M_ST, M_EN, "R11");
        step(1); wake = 0; step(3);

        while (q_due.size() != 0) step(1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule